// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a processor core and decides, every clock, whether the core should leave its current instruction stream to service a peripheral. Each source drives a level-sensitive request line. Each source also has its own enable bit. A single global enable flag, kept inside the block, gates all of them. When several enabled requests are pending, the one with the lowest index wins. The block raises a one-cycle take strobe, presents the winning vector address and pulses an acknowledge back to the chosen source.

The global enable flag is managed here rather than in the core. Accepting an interrupt clears it, so a handler starts with all sources masked. A return strobe from the core restores it. Software may also set or clear it explicitly, and setting it inside a handler permits nesting. The vector table can be moved from address 0 to the boot section base with one select input. A separate configuration input moves the reset slot, independently of the table. Two lock inputs can forbid interrupt entry while the program counter lies in the application region or in the boot region.

Each vector slot is two words wide. Slot 0 of a table belongs to reset, and source i owns slot i+1, so a source vector is base + 2·(i+1). When no interrupt is taken, and for the whole time reset is held, the vector output shows the reset vector.

Top module: `vec_irq_ctrl`

## Requirements
- R1: While rstN is low, takeIrq and irqAck are 0, gieOut is 0, and vecAddr equals the reset vector. The reset vector is BOOT_BASE when rstToBoot is 1 and 0 otherwise. After reset the global enable stays 0 until it is set.
- R2: A take happens only in a cycle where gieOut is 1 and some source i has both irqReq[i] and irqEn[i] at 1. A request whose enable bit is 0 is never taken.
- R3: Among the eligible sources, the one with the lowest index is chosen. irqAck has exactly the chosen bit high, in the same cycle as takeIrq, and is all zeros otherwise.
- R4: During a take, vecAddr = base + 2·(i+1), where i is the chosen index. The base is BOOT_BASE when ivSel is 1 and 0 when ivSel is 0.
- R5: The cycle after a take, gieOut is 0, whatever the set and return strobes did in the take cycle.
- R6: gieSet high in a cycle with no take makes gieOut 1 on the next cycle. This holds inside a handler too, after which a pending enabled source is taken again.
- R7: retStrobe high in a cycle with no take makes gieOut 1 on the next cycle.
- R8: gieClr high, with no take, gieSet or retStrobe in the same cycle, makes gieOut 0 on the next cycle. gieSet and retStrobe take precedence over gieClr.
- R9: The lock inputs suppress takes. lockApp blocks takes while pc < BOOT_BASE, and lockBoot blocks them while pc >= BOOT_BASE. A suppressed request stays pending and is taken once the block no longer applies.
- R10: Outside a take, vecAddr shows the reset vector. The reset slot placement depends only on rstToBoot, and the interrupt table placement depends only on ivSel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | N_SRC | Level request per source |
| irqEn | input | N_SRC | Enable bit per source |
| ivSel | input | 1 | 1 places the interrupt table at BOOT_BASE |
| rstToBoot | input | 1 | 1 places the reset slot at BOOT_BASE |
| pc | input | AW | Current program counter |
| lockApp | input | 1 | Forbid entry while pc is in the application region |
| lockBoot | input | 1 | Forbid entry while pc is in the boot region |
| gieSet | input | 1 | Software request to set the global enable |
| gieClr | input | 1 | Software request to clear the global enable |
| retStrobe | input | 1 | Return-from-interrupt strobe from the core |
| takeIrq | output | 1 | Interrupt accepted this cycle |
| vecAddr | output | AW | Vector for the take, otherwise the reset vector |
| irqAck | output | N_SRC | One-hot acknowledge to the chosen source |
| gieOut | output | 1 | Current global enable state |

## Verification
The hardest case to reach is nesting. A handler must already be running, so a take must have cleared the global enable. Software must then set the flag again, and a different source must be pending at that moment. The stimulus takes a low-priority source first, keeps a higher-priority request waiting behind the cleared flag, and then pulses gieSet. This confirms the waiting source is taken on the following cycle with its own vector. Lock suppression is approached the same way: the program counter is moved across BOOT_BASE while a request is held, so both the blocked and the released case are seen with the request unchanged.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef struct packed {
    logic take;
    logic irqAtBoot;
    logic rstAtBoot;
  } vicStrobe_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] BOOT_BASE = 16'hE000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          anyPend,
  input  logic [AW-1:0] pc,
  input  logic          lockApp,
  input  logic          lockBoot,
  input  logic          ivSel,
  input  logic          rstToBoot,
  input  logic          gieSet,
  input  logic          gieClr,
  input  logic          retStrobe,
  output vicStrobe_t    strb,
  output logic          gieOut
);
  logic gieQ;
  logic inBoot;
  logic blocked;
  logic takeNow;

  assign inBoot  = (pc >= BOOT_BASE);
  assign blocked = (lockApp && !inBoot) || (lockBoot && inBoot);
  assign takeNow = rstN && gieQ && anyPend && !blocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gieQ <= 1'b0;
    end else if (takeNow) begin
      gieQ <= 1'b0;
    end else if (retStrobe || gieSet) begin
      gieQ <= 1'b1;
    end else if (gieClr) begin
      gieQ <= 1'b0;
    end
  end

  always_comb begin
    strb.take      = takeNow;
    strb.irqAtBoot = ivSel;
    strb.rstAtBoot = rstToBoot;
  end

  assign gieOut = gieQ;
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] BOOT_BASE = 16'hE000
) (
  input  logic [N_SRC-1:0] irqReq,
  input  logic [N_SRC-1:0] irqEn,
  input  vicStrobe_t       strb,
  output logic             anyPend,
  output logic [N_SRC-1:0] irqAck,
  output logic [AW-1:0]    vecAddr
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] pend;
  logic [IDX_W-1:0] win;
  logic [AW-1:0]    irqBase;
  logic [AW-1:0]    rstVec;
  logic [AW-1:0]    slotOff;

  assign pend    = irqReq & irqEn;
  assign anyPend = |pend;

  always_comb begin
    win = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i]) win = IDX_W'(i);
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_ack
    assign irqAck[g] = strb.take && (win == IDX_W'(g));
  end

  assign irqBase = strb.irqAtBoot ? BOOT_BASE : '0;
  assign rstVec  = strb.rstAtBoot ? BOOT_BASE : '0;
  assign slotOff = (AW'(win) + AW'(1)) << 1;
  assign vecAddr = strb.take ? (irqBase + slotOff) : rstVec;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] BOOT_BASE = 16'hE000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N_SRC-1:0] irqReq,
  input  logic [N_SRC-1:0] irqEn,
  input  logic             ivSel,
  input  logic             rstToBoot,
  input  logic [AW-1:0]    pc,
  input  logic             lockApp,
  input  logic             lockBoot,
  input  logic             gieSet,
  input  logic             gieClr,
  input  logic             retStrobe,
  output logic             takeIrq,
  output logic [AW-1:0]    vecAddr,
  output logic [N_SRC-1:0] irqAck,
  output logic             gieOut
);
  vicStrobe_t strb;
  logic       anyPend;

  vic_ctrl #(.AW(AW), .BOOT_BASE(BOOT_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .anyPend(anyPend), .pc(pc),
    .lockApp(lockApp), .lockBoot(lockBoot), .ivSel(ivSel),
    .rstToBoot(rstToBoot), .gieSet(gieSet), .gieClr(gieClr),
    .retStrobe(retStrobe), .strb(strb), .gieOut(gieOut)
  );

  vic_datapath #(.N_SRC(N_SRC), .AW(AW), .BOOT_BASE(BOOT_BASE)) u_dp (
    .irqReq(irqReq), .irqEn(irqEn), .strb(strb),
    .anyPend(anyPend), .irqAck(irqAck), .vecAddr(vecAddr)
  );

  assign takeIrq = strb.take;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int N_SRC = 8,
  parameter int AW = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [N_SRC-1:0] irqReq,
  input logic [N_SRC-1:0] irqEn,
  input logic             retStrobe,
  input logic             takeIrq,
  input logic [AW-1:0]    vecAddr,
  input logic [N_SRC-1:0] irqAck,
  input logic             gieOut
);
  p_ack_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqAck));

  p_ack_with_take_r3: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> ($countones(irqAck) == 1));

  p_idle_no_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    !takeIrq |-> (irqAck == '0));

  p_ack_eligible_r2: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck & ~(irqReq & irqEn)) == '0);

  p_take_needs_gie_r2: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> gieOut);

  p_take_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |=> !gieOut);

  p_ret_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !takeIrq) |=> gieOut);

  p_vec_even_r4: assert property (@(posedge clk) disable iff (!rstN)
    takeIrq |-> !vecAddr[0]);
endmodule

bind vec_irq_ctrl vic_chk #(.N_SRC(N_SRC), .AW(AW)) u_vic_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqEn(irqEn),
  .retStrobe(retStrobe), .takeIrq(takeIrq), .vecAddr(vecAddr),
  .irqAck(irqAck), .gieOut(gieOut)
);

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
  localparam int N = 8;
  localparam int AW = 16;
  localparam logic [AW-1:0] BOOT = 16'hE000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] irqReq = '0, irqEn = '0;
  logic ivSel = 1'b0, rstToBoot = 1'b0;
  logic [AW-1:0] pc = '0;
  logic lockApp = 1'b0, lockBoot = 1'b0;
  logic gieSet = 1'b0, gieClr = 1'b0, retStrobe = 1'b0;
  logic takeIrq;
  logic [AW-1:0] vecAddr;
  logic [N-1:0] irqAck;
  logic gieOut;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit mGie = 0;

  always #2 clk = ~clk;

  vec_irq_ctrl #(.N_SRC(N), .AW(AW), .BOOT_BASE(BOOT)) i_vec_irq_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqEn(irqEn), .ivSel(ivSel),
    .rstToBoot(rstToBoot), .pc(pc), .lockApp(lockApp), .lockBoot(lockBoot),
    .gieSet(gieSet), .gieClr(gieClr), .retStrobe(retStrobe),
    .takeIrq(takeIrq), .vecAddr(vecAddr), .irqAck(irqAck), .gieOut(gieOut)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model: compare all outputs mid-cycle, then advance the flag.
  task automatic step(input string tag);
    bit expTake;
    int idx;
    logic [N-1:0] expAck;
    longint expVec;
    bit blk;
    #1;
    idx = -1;
    for (int i = 0; i < N; i++) if (idx < 0 && irqReq[i] && irqEn[i]) idx = i;
    blk = (lockApp && pc < BOOT) || (lockBoot && pc >= BOOT);
    expTake = rstN && mGie && (idx >= 0) && !blk;
    expAck = '0;
    if (expTake) begin
      expAck[idx] = 1'b1;
      expVec = (ivSel ? longint'(BOOT) : 0) + 2 * (idx + 1);
    end else begin
      expVec = rstToBoot ? longint'(BOOT) : 0;
    end
    chk(tag, "takeIrq", takeIrq, expTake);
    chk(tag, "irqAck", irqAck, expAck);
    chk(tag, "vecAddr", vecAddr, expVec);
    chk(tag, "gieOut", gieOut, mGie);
    @(posedge clk);
    if (!rstN) mGie = 0;
    else if (expTake) mGie = 0;
    else if (retStrobe || gieSet) mGie = 1;
    else if (gieClr) mGie = 0;
    @(negedge clk);
  endtask

  task automatic setGie(input string tag);
    gieSet = 1'b1; step(tag); gieSet = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    // R1 and R10: reset vector placement while held in reset
    irqReq = '1; irqEn = '1;
    step("R1");
    rstToBoot = 1'b1; step("R10");
    rstToBoot = 1'b0; ivSel = 1'b1; step("R10");
    ivSel = 1'b0;
    rstN = 1'b1;
    step("R1");   // global enable still 0 after reset: no take (R2)
    // R2: disabled source never taken
    irqReq = 8'h10; irqEn = 8'hEF;
    setGie("R6");
    step("R2"); step("R2");
    // R3/R4: lowest eligible index wins
    irqReq = 8'hA4; irqEn = 8'hFF;
    step("R3");   // take idx 2, vector 6
    step("R5");   // flag now clear, no take
    ivSel = 1'b1; setGie("R6");
    step("R4");   // take idx 2 at boot table
    ivSel = 1'b0;
    // R6: nesting - low source taken, higher source arrives while masked
    irqReq = 8'h80; irqEn = 8'hFF; setGie("R6");
    step("R6");   // idx 7 taken
    irqReq = 8'h82; step("R5");
    setGie("R6");
    step("R6");   // idx 1 preempts
    // R7: return sets; R8 clear and precedence
    irqReq = '0;
    retStrobe = 1'b1; step("R7"); retStrobe = 1'b0;
    step("R7");
    gieClr = 1'b1; step("R8"); gieClr = 1'b0;
    step("R8");
    gieClr = 1'b1; retStrobe = 1'b1; step("R8");
    gieClr = 1'b0; retStrobe = 1'b0; step("R8");
    gieClr = 1'b1; gieSet = 1'b1; step("R8");
    gieClr = 1'b0; gieSet = 1'b0; step("R8");
    // R5: return strobe during a take does not keep the flag
    irqReq = 8'h08; retStrobe = 1'b1; step("R5");
    retStrobe = 1'b0; step("R5");
    // R9: lock suppression by region
    setGie("R9");
    lockApp = 1'b1; pc = 16'h0100; step("R9"); step("R9");
    pc = BOOT + 16'h0010; step("R9");   // released, taken
    setGie("R9");
    lockApp = 1'b0; lockBoot = 1'b1; step("R9");
    pc = 16'h0200; step("R9");          // taken from application region
    lockBoot = 1'b0;
    // R10: reset slot moved independently of table during a run
    rstToBoot = 1'b1; ivSel = 1'b0; irqReq = 8'h01;
    step("R10");
    setGie("R10");
    step("R10");  // take idx 0 at vector 2 while reset slot at boot
    irqReq = '0; step("R10");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule